// File: doc/BRIEF.md
# Multi-Channel Transmit Line Control

This block is the digital control stage that sits in front of the line drivers of a multi-channel T1/E1 transmitter. Every channel receives a transmit bit clock plus a pair of rail inputs (one marks a positive pulse, the other a negative pulse). A single chip-wide setting chooses whether the data is taken on the rising edge or the falling edge of that clock. The captured pair then goes to the line driver as a pair of rail outputs, along with a per-channel output-enable flag.

The transmit clock is oversampled on a free-running reference clock. When a channel sees no edge of the chosen polarity for a set number of reference cycles, it treats its transmit clock as lost and drives zeros on both rails. The first good edge afterwards clears that condition. Each channel also has an all-ones alarm override, which sends one pulse per bit period with alternating polarity. Clock loss takes priority over this override.

The output enable of each channel comes from one of two sources: a register-driven bit, or a dedicated per-channel pin. A global control bit picks which one is used. Every output enable is low at reset. Whenever a channel's enable is low, both of its rails are held at zero.

Top module: `txctl_top`

## Requirements
- R1: With `edge_fall_i` = 0, each channel latches the rail pair present at a rising edge of its transmit clock and presents it on `line_pos_o`/`line_neg_o` (1 = pulse on that rail); data changed between that rising edge and the following falling edge has no effect.
- R2: With `edge_fall_i` = 1, each channel latches the rail pair present at a falling edge of its transmit clock; data present only at the rising edge has no effect.
- R3: The single `edge_fall_i` setting applies to all channels at once.
- R4: If a channel sees no selected transmit-clock edge for `LOSS_LIMIT` (default 32) reference cycles, with its clock held either low or held high, both of its rails become 0. The first selected edge after that restores the rails to the data latched at that edge.
- R5: While `all_ones_i[c]` = 1, every bit period of channel c carries exactly one pulse. The pulse alternates between the positive and the negative rail on consecutive bit periods.
- R6: While `all_ones_i[c]` = 0, channel c passes its latched input data unchanged.
- R7: Clock loss forces both rails to 0 even while the all-ones override is active.
- R8: During reset and on release from reset, every `line_oe_o` bit is 0 and every rail is 0.
- R9: With `pin_ctl_i` = 0, `line_oe_o[c]` follows `en_reg_i[c]` one reference cycle later, and `en_pin_i` has no effect.
- R10: With `pin_ctl_i` = 1, `line_oe_o[c]` follows `en_pin_i[c]` one reference cycle later, and `en_reg_i` has no effect.
- R11: Whenever `line_oe_o[c]` = 0, both rails of channel c are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low reset |
| tx_clk_i | input | N_CH | Transmit bit clock, one per channel |
| tx_pos_i | input | N_CH | Positive-rail data input, one per channel |
| tx_neg_i | input | N_CH | Negative-rail data input, one per channel |
| edge_fall_i | input | 1 | Global edge select: 0 = rising, 1 = falling |
| all_ones_i | input | N_CH | Per-channel all-ones alarm override |
| en_reg_i | input | N_CH | Register-driven per-channel output enable |
| en_pin_i | input | N_CH | Pin-driven per-channel output enable |
| pin_ctl_i | input | 1 | 1 = enables come from en_pin_i, 0 = from en_reg_i |
| line_pos_o | output | N_CH | Positive-rail line symbol |
| line_neg_o | output | N_CH | Negative-rail line symbol |
| line_oe_o | output | N_CH | Output enable to the line driver |

## Verification
A loss counter left in a bad state shows up at the rails in one of two ways. Either they drop to zero while the clock is still toggling, or they keep stale data more than a few cycles after `LOSS_LIMIT` reference periods of a stuck clock. Both cases are visible within about forty reference cycles. A wrong polarity bit in the all-ones path shows up within two bit periods, as the same rail pulsing twice in a row. A bad edge choice shows up on the first bit that carries different data at its rising edge and at its falling edge. Enable arbitration is observed one cycle after any change to the enable inputs, and the rails are checked to be zero whenever the enable is low.

// File: rtl/txctl_pkg.sv
package txctl_pkg;

    // Oversampling pipeline of one channel: clock has one extra stage for edge detection
    typedef struct packed {
        logic clk1;
        logic clk2;
        logic clk3;
        logic pos1;
        logic pos2;
        logic neg1;
        logic neg2;
    } txc_sync_t;

    // Latched line symbol pair
    typedef struct packed {
        logic p;
        logic n;
    } txc_sym_t;

endpackage

// File: rtl/txctl_edge_sync.sv
module txctl_edge_sync
    import txctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tclk_i,
    input  logic pos_i,
    input  logic neg_i,
    output logic rise_o,
    output logic fall_o,
    output logic pos_o,
    output logic neg_o
);

    txc_sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.clk1 = tclk_i;
        s_d.clk2 = s_q.clk1;
        s_d.clk3 = s_q.clk2;
        s_d.pos1 = pos_i;
        s_d.pos2 = s_q.pos1;
        s_d.neg1 = neg_i;
        s_d.neg2 = s_q.neg1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Data at stage 2 is the sample taken together with the new clock level
    assign rise_o = s_q.clk2 & ~s_q.clk3;
    assign fall_o = ~s_q.clk2 & s_q.clk3;
    assign pos_o  = s_q.pos2;
    assign neg_o  = s_q.neg2;

endmodule

// File: rtl/txctl_lane.sv
module txctl_lane
    import txctl_pkg::*;
#(
    parameter int LOSS_LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic fall_i,
    input  logic pos_i,
    input  logic neg_i,
    input  logic edge_fall_i,
    input  logic all_ones_i,
    input  logic oe_sel_i,
    output logic line_pos_o,
    output logic line_neg_o,
    output logic line_oe_o
);

    localparam int CNT_W = $clog2(LOSS_LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOSS_LIMIT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        txc_sym_t         sym;
        logic             pol;
        logic             oe;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic     take_edge;
    logic     lost;

    assign take_edge = edge_fall_i ? fall_i : rise_i;
    assign lost      = (st_q.cnt == CNT_MAX);

    always_comb begin
        st_d    = st_q;
        st_d.oe = oe_sel_i;
        if (take_edge) begin
            st_d.cnt = '0;
            if (all_ones_i) begin
                st_d.sym.p = ~st_q.pol;
                st_d.sym.n = st_q.pol;
                st_d.pol   = ~st_q.pol;
            end else begin
                st_d.sym.p = pos_i;
                st_d.sym.n = neg_i;
            end
        end else if (!lost) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= CNT_MAX;   // no clock seen yet: start in loss
            st_q.sym <= '0;
            st_q.pol <= 1'b0;
            st_q.oe  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_oe_o  = st_q.oe;
    assign line_pos_o = st_q.oe & ~lost & st_q.sym.p;
    assign line_neg_o = st_q.oe & ~lost & st_q.sym.n;

endmodule

// File: rtl/txctl_top.sv
module txctl_top #(
    parameter int N_CH       = 8,
    parameter int LOSS_LIMIT = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] tx_clk_i,
    input  logic [N_CH-1:0] tx_pos_i,
    input  logic [N_CH-1:0] tx_neg_i,
    input  logic            edge_fall_i,
    input  logic [N_CH-1:0] all_ones_i,
    input  logic [N_CH-1:0] en_reg_i,
    input  logic [N_CH-1:0] en_pin_i,
    input  logic            pin_ctl_i,
    output logic [N_CH-1:0] line_pos_o,
    output logic [N_CH-1:0] line_neg_o,
    output logic [N_CH-1:0] line_oe_o
);

    logic [N_CH-1:0] rise, fall, spos, sneg, oe_sel;

    assign oe_sel = pin_ctl_i ? en_pin_i : en_reg_i;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        txctl_edge_sync u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .tclk_i (tx_clk_i[c]),
            .pos_i  (tx_pos_i[c]),
            .neg_i  (tx_neg_i[c]),
            .rise_o (rise[c]),
            .fall_o (fall[c]),
            .pos_o  (spos[c]),
            .neg_o  (sneg[c])
        );

        txctl_lane #(.LOSS_LIMIT(LOSS_LIMIT)) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .rise_i      (rise[c]),
            .fall_i      (fall[c]),
            .pos_i       (spos[c]),
            .neg_i       (sneg[c]),
            .edge_fall_i (edge_fall_i),
            .all_ones_i  (all_ones_i[c]),
            .oe_sel_i    (oe_sel[c]),
            .line_pos_o  (line_pos_o[c]),
            .line_neg_o  (line_neg_o[c]),
            .line_oe_o   (line_oe_o[c])
        );
    end

endmodule

// File: rtl/txctl_chk.sv
module txctl_chk #(
    parameter int N_CH       = 8,
    parameter int LOSS_LIMIT = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_CH-1:0] tx_clk_i,
    input logic [N_CH-1:0] en_reg_i,
    input logic [N_CH-1:0] en_pin_i,
    input logic            pin_ctl_i,
    input logic [N_CH-1:0] line_pos_o,
    input logic [N_CH-1:0] line_neg_o,
    input logic [N_CH-1:0] line_oe_o
);

    localparam int STUCK_TH = LOSS_LIMIT + 6;
    localparam int STK_W    = $clog2(STUCK_TH + 1);

    // R11: a disabled channel never pulses
    assert_rails_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_pos_o | line_neg_o) & ~line_oe_o) == '0);

    // R8: enables come out of reset low
    assert_reset_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (line_oe_o == '0 && line_pos_o == '0 && line_neg_o == '0));

    // R9 / R10: enable source arbitration, one cycle later
    assert_oe_source_R9_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> line_oe_o == $past(pin_ctl_i ? en_pin_i : en_reg_i));

    // R4: a transmit clock stuck longer than the limit gives zero rails
    for (genvar c = 0; c < N_CH; c++) begin : g_stk
        logic [STK_W-1:0] stk_q;
        logic             prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stk_q  <= '0;
                prev_q <= 1'b0;
            end else begin
                prev_q <= tx_clk_i[c];
                if (tx_clk_i[c] != prev_q)            stk_q <= '0;
                else if (stk_q != STK_W'(STUCK_TH))   stk_q <= stk_q + STK_W'(1);
            end
        end
        assert_stuck_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (stk_q == STK_W'(STUCK_TH)) |-> (!line_pos_o[c] && !line_neg_o[c]));
    end

endmodule

bind txctl_top txctl_chk #(.N_CH(N_CH), .LOSS_LIMIT(LOSS_LIMIT)) chk_i (.*);

// File: tb/txctl_top_tb_top.sv
`timescale 1ns/1ps
module txctl_top_tb_top;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] tx_clk = '0, tx_pos = '0, tx_neg = '0;
    logic         edge_fall = 1'b0;
    logic [N-1:0] all_ones = '0, en_reg = '0, en_pin = '0;
    logic         pin_ctl = 1'b0;
    logic [N-1:0] line_pos, line_neg, line_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    txctl_top #(.N_CH(N), .LOSS_LIMIT(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_clk_i(tx_clk), .tx_pos_i(tx_pos),
        .tx_neg_i(tx_neg), .edge_fall_i(edge_fall), .all_ones_i(all_ones),
        .en_reg_i(en_reg), .en_pin_i(en_pin), .pin_ctl_i(pin_ctl),
        .line_pos_o(line_pos), .line_neg_o(line_neg), .line_oe_o(line_oe)
    );

    typedef struct packed {
        logic       fall;
        logic       pinc;
        logic [7:0] enr;
        logic [7:0] enp;
        logic [7:0] pos;
        logic [7:0] neg;
        logic [7:0] xp;
        logic [7:0] xn;
        logic [7:0] xoe;
    } vec_t;

    // R1 R2 R3 R6 R9 R10 R11: expected oe = pinc ? enp : enr, rails = data & oe
    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 8'hFF, 8'h00, 8'hA5, 8'h5A, 8'hA5, 8'h5A, 8'hFF},
        '{1'b0, 1'b0, 8'h0F, 8'hF0, 8'hFF, 8'h00, 8'h0F, 8'h00, 8'h0F},
        '{1'b0, 1'b1, 8'h0F, 8'hF0, 8'hFF, 8'h00, 8'hF0, 8'h00, 8'hF0},
        '{1'b1, 1'b0, 8'hFF, 8'hFF, 8'h33, 8'hCC, 8'h33, 8'hCC, 8'hFF},
        '{1'b1, 1'b1, 8'h00, 8'hFF, 8'hC3, 8'h3C, 8'hC3, 8'h3C, 8'hFF},
        '{1'b1, 1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00},
        '{1'b0, 1'b1, 8'hAA, 8'h55, 8'h0F, 8'hF0, 8'h05, 8'h50, 8'h55},
        '{1'b0, 1'b0, 8'hAA, 8'h55, 8'h0F, 8'hF0, 8'h0A, 8'hA0, 8'hAA}
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bit period: data A held around the rising edge, data B around the falling edge
    task automatic send_ab(input logic [7:0] pa, na, pb, nb);
        tx_pos = pa; tx_neg = na;
        cyc(4); tx_clk = '1;
        cyc(4); tx_pos = pb; tx_neg = nb;
        cyc(4); tx_clk = '0;
        cyc(4);
    endtask

    task automatic send_bit(input logic [7:0] p, n);
        send_ab(p, n, p, n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    logic [7:0] pp, pn;

    initial begin
        en_reg = '1;
        cyc(3);
        chk("R8 oe during reset", line_oe, 8'h00);
        chk("R8 pos during reset", line_pos, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        chk("R8 oe at release", line_oe, 8'h00);
        cyc(2);
        send_bit(8'hFF, 8'h00);

        // vector table
        for (int i = 0; i < 8; i++) begin
            edge_fall = VECS[i].fall;
            pin_ctl   = VECS[i].pinc;
            en_reg    = VECS[i].enr;
            en_pin    = VECS[i].enp;
            send_bit(VECS[i].pos, VECS[i].neg);
            chk($sformatf("R9/R10 oe vec %0d", i), line_oe, VECS[i].xoe);
            chk($sformatf("R1/R2/R3/R6/R11 pos vec %0d", i), line_pos, VECS[i].xp);
            chk($sformatf("R1/R2/R3/R6/R11 neg vec %0d", i), line_neg, VECS[i].xn);
        end

        pin_ctl = 1'b0; en_reg = '1; en_pin = '0;

        // R1: rising edge takes A
        edge_fall = 1'b0;
        send_ab(8'h3C, 8'h81, 8'hC3, 8'h18);
        chk("R1 rising pos", line_pos, 8'h3C);
        chk("R1 rising neg", line_neg, 8'h81);
        // R2: falling edge takes B
        edge_fall = 1'b1;
        send_ab(8'h3C, 8'h81, 8'hC3, 8'h18);
        chk("R2 falling pos", line_pos, 8'hC3);
        chk("R2 falling neg", line_neg, 8'h18);

        // R4: clock held low
        edge_fall = 1'b0;
        send_bit(8'h96, 8'h00);
        cyc(10);
        chk("R4 short gap keeps data", line_pos, 8'h96);
        cyc(30);
        chk("R4 stuck low pos", line_pos, 8'h00);
        send_bit(8'h69, 8'h00);
        chk("R4 restore after low", line_pos, 8'h69);
        // R4: clock held high
        tx_pos = 8'h5A; cyc(4); tx_clk = '1; cyc(6);
        chk("R4 data before stuck high", line_pos, 8'h5A);
        cyc(40);
        chk("R4 stuck high pos", line_pos, 8'h00);
        tx_clk = '0; cyc(4);
        send_bit(8'hA5, 8'h00);
        chk("R4 restore after high", line_pos, 8'hA5);

        // R5: all-ones on channel 0, others pass data (R6)
        all_ones = 8'h01;
        send_bit(8'hFE, 8'h00);
        chk("R5 one pulse bit1", {7'd0, line_pos[0] ^ line_neg[0]}, 8'h01);
        chk("R6 others pass", line_pos & 8'hFE, 8'hFE);
        pp = line_pos; pn = line_neg;
        for (int b = 0; b < 3; b++) begin
            send_bit(8'hFE, 8'h00);
            chk("R5 alternate pos", {7'd0, line_pos[0]}, {7'd0, pn[0]});
            chk("R5 alternate neg", {7'd0, line_neg[0]}, {7'd0, pp[0]});
            pp = line_pos; pn = line_neg;
        end

        // R7: loss beats all-ones
        all_ones = '1;
        send_bit(8'h00, 8'h00);
        cyc(45);
        chk("R7 loss over all-ones pos", line_pos, 8'h00);
        chk("R7 loss over all-ones neg", line_neg, 8'h00);
        all_ones = '0;
        send_bit(8'h0F, 8'hF0);
        chk("R6 passthrough after override", line_pos, 8'h0F);

        // R8: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        cyc(2);
        chk("R8 oe mid-run reset", line_oe, 8'h00);
        chk("R8 neg mid-run reset", line_neg, 8'h00);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule